// File: doc/BRIEF.md
# Display Window Update Sequencer

This block sits between a pixel source and a byte-wide command port of a frame-memory display controller. After the chip comes out of reset it takes the panel through a timed hardware reset. It then reads the panel's power-mode byte once, so the rest of the chip can tell whether the panel is already showing an image. After that it accepts one request at a time. A request can redraw a rectangle, enable the pipeline, or disable it.

A redraw emits a command sequence in a fixed order. First comes the column window command with four argument bytes, then the row window command with four argument bytes, then the memory write command followed by two bytes per pixel, high byte first. Pixels are pulled from the pixel source in raster order. Enabling the pipeline redraws the whole panel at once. Disabling it on a board with no backlight control fills the whole panel with black, which is generated inside the block without touching the pixel source.

The state machine runs through these states:

- `ST_RST_LO` moves to `ST_RST_WAIT` after the low time.
- `ST_RST_WAIT` moves to `ST_PWR_CMD` after the settle time.
- `ST_PWR_CMD` moves to `ST_PWR_RSP` once the read byte is taken.
- `ST_PWR_RSP` moves to `ST_IDLE` when the response arrives.
- `ST_IDLE` moves to `ST_COL_CMD` when an accepted request starts a sequence. Otherwise it stays in `ST_IDLE`.
- `ST_COL_CMD` moves to `ST_COL_ARG`, which moves to `ST_ROW_CMD` after four bytes.
- `ST_ROW_CMD` moves to `ST_ROW_ARG`, which moves to `ST_MEM_CMD` after four bytes.
- `ST_MEM_CMD` moves to `ST_PIX_GET`, or to `ST_DONE` for an empty area.
- `ST_PIX_GET` moves to `ST_PIX_HI`, then to `ST_PIX_LO`.
- `ST_PIX_LO` moves back to `ST_PIX_GET`, or to `ST_DONE` after the last pixel.
- `ST_DONE` moves to `ST_IDLE`.

Top module: `winupd_seq`

## Requirements
- R1: From reset release, `panel_rst_n` stays low for RST_LOW_MS millisecond periods (of CYC_PER_MS clocks each) and then goes high. No byte is offered on the command port until RST_LOW_MS+RST_WAIT_MS periods have passed. The first byte appears right after that, once edge number (RST_LOW_MS+RST_WAIT_MS)*CYC_PER_MS has occurred.
- R2: The first byte offered is the power-mode read command 0x0A, with `out_rd`=1 and `out_dc`=0. The block then waits for `rsp_valid`. `disp_on` becomes 1 only when the response ANDed with 0x7C equals 0x1C; otherwise it becomes 0. `disp_on` is 0 out of reset.
- R3: A sequence starts with command 0x2A (`out_dc`=0). Four argument bytes (`out_dc`=1) follow, in this order: the high byte of the left column, its low byte, the high byte of (right edge − 1), and its low byte. The right edge of a request is exclusive.
- R4: Next comes command 0x2B with the same four-byte layout, built from the top row and (bottom edge − 1).
- R5: Next comes command 0x2C. It is followed by (x1−x0)×(y1−y0) pixels, each sent as two bytes with `out_dc`=1, high byte first. The pixels are taken one by one from the pixel source in the order it supplies them.
- R6: A request with `req_op`=0 (update) accepted while the pipeline is disabled produces no byte and no pixel fetch. No `seq_done` follows, and `req_ready` is high again on the next cycle.
- R7: A request with `req_op`=1 (enable) marks the pipeline enabled. It then runs a full-panel sequence over columns 0..H_RES and rows 0..V_RES, with pixels from the source.
- R8: A request with `req_op`=2 (disable) marks the pipeline disabled. When `bl_present`=0 it runs a full-panel sequence whose pixel bytes are all zero, and the pixel source is not read. When `bl_present`=1 it emits nothing.
- R9: A request is taken only in a cycle where `req_ready` is high. `req_ready` is high only while no sequence is in flight, and nothing is emitted in that state. Each sequence ends with a single-cycle `seq_done` pulse. `req_op`=3 has no effect.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_dc` and `out_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bl_present | input | 1 | Board has backlight control; disable then skips blanking |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_op | input | 2 | 0 update, 1 enable, 2 disable, 3 none |
| req_x0 | input | COORD_W | Left column, inclusive |
| req_x1 | input | COORD_W | Right edge, exclusive |
| req_y0 | input | COORD_W | Top row, inclusive |
| req_y1 | input | COORD_W | Bottom edge, exclusive |
| seq_done | output | 1 | One-cycle pulse at the end of a sequence |
| disp_on | output | 1 | Power-mode self-check result |
| panel_rst_n | output | 1 | Panel hardware reset line, active low |
| pix_valid | input | 1 | Pixel source has a pixel |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| pix_data | input | 16 | RGB565 pixel |
| out_valid | output | 1 | Command port byte valid |
| out_ready | input | 1 | Command port takes the byte |
| out_dc | output | 1 | 0 command byte, 1 argument or pixel byte |
| out_rd | output | 1 | The command byte is a read |
| out_data | output | 8 | Byte value |
| rsp_valid | input | 1 | Read response present |
| rsp_data | input | 8 | Read response byte |

## Verification
The properties assume that the command port answers a read with exactly one `rsp_valid` pulse, and only after it has taken the read byte. They also assume that request rectangles have x1 > x0 and y1 > y0, and that `req_valid` with its fields is held while it is offered. The stimulus sends the single response a few cycles after the read byte is accepted. It drives every rectangle with non-empty extents, one of which crosses the 255/256 column boundary. It presents each request only in a cycle where `req_ready` is high and withdraws it on the following cycle. `out_ready` and `pix_valid` are throttled with fixed stall patterns, so the hold and fetch paths are both exercised.

// File: rtl/winupd_pkg.sv
package winupd_pkg;

    typedef enum logic [1:0] {
        OP_UPDATE  = 2'd0,
        OP_ENABLE  = 2'd1,
        OP_DISABLE = 2'd2,
        OP_NONE    = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        ST_RST_LO,
        ST_RST_WAIT,
        ST_PWR_CMD,
        ST_PWR_RSP,
        ST_IDLE,
        ST_COL_CMD,
        ST_COL_ARG,
        ST_ROW_CMD,
        ST_ROW_ARG,
        ST_MEM_CMD,
        ST_PIX_GET,
        ST_PIX_HI,
        ST_PIX_LO,
        ST_DONE
    } state_e;

    localparam logic [7:0] CMD_COL_WIN = 8'h2A;
    localparam logic [7:0] CMD_ROW_WIN = 8'h2B;
    localparam logic [7:0] CMD_MEM_WR  = 8'h2C;
    localparam logic [7:0] CMD_PWR_RD  = 8'h0A;
    localparam logic [7:0] PWR_KEEP    = 8'h7C;
    localparam logic [7:0] PWR_LIVE    = 8'h1C;

endpackage

// File: rtl/winupd_tick.sv
module winupd_tick #(
    parameter int CYC_PER_MS = 250000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2((CYC_PER_MS > 1) ? CYC_PER_MS : 2);
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/winupd_geom.sv
module winupd_geom #(
    parameter int COORD_W = 16,
    localparam int NPW = 2 * COORD_W
) (
    input  logic [COORD_W-1:0] x0,
    input  logic [COORD_W-1:0] x1,
    input  logic [COORD_W-1:0] y0,
    input  logic [COORD_W-1:0] y1,
    output logic [31:0]        col_arg,
    output logic [31:0]        row_arg,
    output logic [NPW-1:0]     npix
);
    logic [COORD_W-1:0] x_last, y_last;

    always_comb begin
        x_last  = x1 - COORD_W'(1);
        y_last  = y1 - COORD_W'(1);
        col_arg = {16'(x0), 16'(x_last)};
        row_arg = {16'(y0), 16'(y_last)};
        npix    = NPW'(x1 - x0) * NPW'(y1 - y0);
    end
endmodule

// File: rtl/winupd_seq.sv
module winupd_seq
    import winupd_pkg::*;
#(
    parameter int CYC_PER_MS  = 250000,
    parameter int H_RES       = 240,
    parameter int V_RES       = 320,
    parameter int COORD_W     = 16,
    parameter int RST_LOW_MS  = 20,
    parameter int RST_WAIT_MS = 120
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bl_present,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [1:0]         req_op,
    input  logic [COORD_W-1:0] req_x0,
    input  logic [COORD_W-1:0] req_x1,
    input  logic [COORD_W-1:0] req_y0,
    input  logic [COORD_W-1:0] req_y1,
    output logic               seq_done,
    output logic               disp_on,
    output logic               panel_rst_n,
    input  logic               pix_valid,
    output logic               pix_ready,
    input  logic [15:0]        pix_data,
    output logic               out_valid,
    input  logic               out_ready,
    output logic               out_dc,
    output logic               out_rd,
    output logic [7:0]         out_data,
    input  logic               rsp_valid,
    input  logic [7:0]         rsp_data
);
    localparam int MS_MAX = (RST_WAIT_MS > RST_LOW_MS) ? RST_WAIT_MS : RST_LOW_MS;
    localparam int MSW    = $clog2(MS_MAX + 1);
    localparam int NPW    = 2 * COORD_W;
    localparam logic [COORD_W-1:0] FULL_W = COORD_W'(H_RES);
    localparam logic [COORD_W-1:0] FULL_H = COORD_W'(V_RES);

    state_e             state_q, state_d;
    logic               enabled_q, blank_q, disp_on_q;
    logic [MSW-1:0]     ms_q;
    logic [1:0]         arg_q;
    logic [NPW-1:0]     left_q;
    logic [15:0]        pix_q;
    logic [COORD_W-1:0] x0_q, x1_q, y0_q, y1_q;
    logic               tick;
    logic [31:0]        col_arg, row_arg;
    logic [NPW-1:0]     npix;
    logic               starts_seq;

    winupd_tick #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    winupd_geom #(.COORD_W(COORD_W)) u_geom (
        .x0     (x0_q),
        .x1     (x1_q),
        .y0     (y0_q),
        .y1     (y1_q),
        .col_arg(col_arg),
        .row_arg(row_arg),
        .npix   (npix)
    );

    // Whether an accepted request opens a command sequence
    always_comb begin
        unique case (op_e'(req_op))
            OP_UPDATE:  starts_seq = enabled_q;
            OP_ENABLE:  starts_seq = 1'b1;
            OP_DISABLE: starts_seq = !bl_present;
            default:    starts_seq = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST_LO:   if (tick && ms_q == MSW'(RST_LOW_MS - 1))  state_d = ST_RST_WAIT;
            ST_RST_WAIT: if (tick && ms_q == MSW'(RST_WAIT_MS - 1)) state_d = ST_PWR_CMD;
            ST_PWR_CMD:  if (out_ready) state_d = ST_PWR_RSP;
            ST_PWR_RSP:  if (rsp_valid) state_d = ST_IDLE;
            ST_IDLE:     if (req_valid && starts_seq) state_d = ST_COL_CMD;
            ST_COL_CMD:  if (out_ready) state_d = ST_COL_ARG;
            ST_COL_ARG:  if (out_ready && arg_q == 2'd3) state_d = ST_ROW_CMD;
            ST_ROW_CMD:  if (out_ready) state_d = ST_ROW_ARG;
            ST_ROW_ARG:  if (out_ready && arg_q == 2'd3) state_d = ST_MEM_CMD;
            ST_MEM_CMD:  if (out_ready) state_d = (npix == '0) ? ST_DONE : ST_PIX_GET;
            ST_PIX_GET:  if (blank_q || pix_valid) state_d = ST_PIX_HI;
            ST_PIX_HI:   if (out_ready) state_d = ST_PIX_LO;
            ST_PIX_LO:   if (out_ready) state_d = (left_q == NPW'(1)) ? ST_DONE : ST_PIX_GET;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_RST_LO;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST_LO;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enabled_q <= 1'b0;
            blank_q   <= 1'b0;
            disp_on_q <= 1'b0;
            ms_q      <= '0;
            arg_q     <= '0;
            left_q    <= '0;
            pix_q     <= '0;
            x0_q      <= '0;
            x1_q      <= '0;
            y0_q      <= '0;
            y1_q      <= '0;
        end else begin
            if ((state_q == ST_RST_LO || state_q == ST_RST_WAIT) && tick)
                ms_q <= (state_d != state_q) ? '0 : ms_q + 1'b1;
            if (state_q == ST_PWR_RSP && rsp_valid)
                disp_on_q <= ((rsp_data & PWR_KEEP) == PWR_LIVE);
            if (state_q == ST_IDLE && req_valid) begin
                unique case (op_e'(req_op))
                    OP_UPDATE: begin
                        x0_q <= req_x0; x1_q <= req_x1;
                        y0_q <= req_y0; y1_q <= req_y1;
                        blank_q <= 1'b0;
                    end
                    OP_ENABLE: begin
                        enabled_q <= 1'b1;
                        x0_q <= '0; x1_q <= FULL_W;
                        y0_q <= '0; y1_q <= FULL_H;
                        blank_q <= 1'b0;
                    end
                    OP_DISABLE: begin
                        enabled_q <= 1'b0;
                        x0_q <= '0; x1_q <= FULL_W;
                        y0_q <= '0; y1_q <= FULL_H;
                        blank_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
            if ((state_q == ST_COL_ARG || state_q == ST_ROW_ARG) && out_ready)
                arg_q <= arg_q + 1'b1;
            if (state_q == ST_MEM_CMD && out_ready)
                left_q <= npix;
            if (state_q == ST_PIX_GET)
                pix_q <= blank_q ? 16'h0000 : pix_data;
            if (state_q == ST_PIX_LO && out_ready)
                left_q <= left_q - 1'b1;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        out_valid   = 1'b0;
        out_dc      = 1'b0;
        out_rd      = 1'b0;
        out_data    = 8'h00;
        pix_ready   = 1'b0;
        req_ready   = 1'b0;
        seq_done    = 1'b0;
        panel_rst_n = 1'b1;
        unique case (state_q)
            ST_RST_LO:   panel_rst_n = 1'b0;
            ST_PWR_CMD:  begin out_valid = 1'b1; out_rd = 1'b1; out_data = CMD_PWR_RD; end
            ST_IDLE:     req_ready = 1'b1;
            ST_COL_CMD:  begin out_valid = 1'b1; out_data = CMD_COL_WIN; end
            ST_COL_ARG:  begin out_valid = 1'b1; out_dc = 1'b1; out_data = col_arg[{~arg_q, 3'b000} +: 8]; end
            ST_ROW_CMD:  begin out_valid = 1'b1; out_data = CMD_ROW_WIN; end
            ST_ROW_ARG:  begin out_valid = 1'b1; out_dc = 1'b1; out_data = row_arg[{~arg_q, 3'b000} +: 8]; end
            ST_MEM_CMD:  begin out_valid = 1'b1; out_data = CMD_MEM_WR; end
            ST_PIX_GET:  pix_ready = !blank_q;
            ST_PIX_HI:   begin out_valid = 1'b1; out_dc = 1'b1; out_data = pix_q[15:8]; end
            ST_PIX_LO:   begin out_valid = 1'b1; out_dc = 1'b1; out_data = pix_q[7:0]; end
            ST_DONE:     seq_done = 1'b1;
            default: ;
        endcase
    end

    assign disp_on = disp_on_q;
endmodule

// File: rtl/winupd_chk.sv
module winupd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       out_ready,
    input logic       out_dc,
    input logic       out_rd,
    input logic [7:0] out_data,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_op,
    input logic       enabled_q,
    input logic       seq_done,
    input logic       panel_rst_n,
    input logic       pix_ready
);
    a_r1_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_n |-> !out_valid);

    a_r2_read_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_rd) |-> (out_data == 8'h0A && !out_dc));

    a_r6_drop_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd0 && !enabled_q) |=> req_ready);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!out_valid && !pix_ready));

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dc)));
endmodule

bind winupd_seq winupd_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_dc     (out_dc),
    .out_rd     (out_rd),
    .out_data   (out_data),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .enabled_q  (enabled_q),
    .seq_done   (seq_done),
    .panel_rst_n(panel_rst_n),
    .pix_ready  (pix_ready)
);

// File: tb/tb_winupd_seq.sv
`timescale 1ns/1ps
module tb_winupd_seq;
    localparam int CPM = 4;
    localparam int HR  = 6;
    localparam int VR  = 4;
    localparam int LOW = 20;
    localparam int WT  = 120;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bl_present = 1'b0, req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [15:0] req_x0 = '0, req_x1 = '0, req_y0 = '0, req_y1 = '0;
    logic pix_valid = 1'b0, out_ready = 1'b0, rsp_valid = 1'b0;
    logic [15:0] pix_data = '0;
    logic [7:0] rsp_data = '0;
    logic req_ready, seq_done, disp_on, panel_rst_n, pix_ready;
    logic out_valid, out_dc, out_rd;
    logic [7:0] out_data;

    winupd_seq #(.CYC_PER_MS(CPM), .H_RES(HR), .V_RES(VR), .COORD_W(16),
                 .RST_LOW_MS(LOW), .RST_WAIT_MS(WT)) dut (
        .clk(clk), .rst_n(rst_n), .bl_present(bl_present),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_x0(req_x0), .req_x1(req_x1), .req_y0(req_y0), .req_y1(req_y1),
        .seq_done(seq_done), .disp_on(disp_on), .panel_rst_n(panel_rst_n),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_dc(out_dc),
        .out_rd(out_rd), .out_data(out_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    always #2 clk = ~clk;

    int total = 0, bad = 0, cyc = 0, n_edge = 0;
    int pix_idx = 0, done_cnt = 0, rsp_cnt = 0;
    bit pend = 0, first_seen = 0, model_en = 0, prev_stall = 0;
    logic [9:0] prev_byte;
    logic [7:0] pm_val = 8'h00;
    logic [9:0] expq[$];
    string tagq[$];

    function automatic logic [15:0] pixf(input int k);
        return 16'(k * 16'h0123 + 16'h5A3C);
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) n_edge <= rst_n ? n_edge + 1 : 0;

    // Per-cycle reference comparison
    always @(negedge clk) begin
        bit rdy, pv;
        logic [9:0] got, e;
        string t;
        cyc++;
        if (cyc > 150000) begin
            chk(0, "R9", "watchdog expired", cyc, 0);
            finish_run();
        end
        if (rst_n) begin
            chk(panel_rst_n == (n_edge >= LOW * CPM), "R1", "panel reset line", panel_rst_n, n_edge >= LOW * CPM);
            if (out_valid && !first_seen) begin
                first_seen = 1;
                chk(n_edge == (LOW + WT) * CPM, "R1", "edge of first byte", n_edge, (LOW + WT) * CPM);
            end
            if (prev_stall)
                chk(out_valid && {out_rd, out_dc, out_data} == prev_byte, "R10", "held byte",
                    {out_valid, out_rd, out_dc, out_data}, {1'b1, prev_byte});
            if (seq_done) done_cnt++;
        end
        if (pend) pix_idx++;
        pv = (cyc % 5) != 2;
        pix_valid = pv;
        pix_data = pixf(pix_idx);
        pend = rst_n && pv && pix_ready;
        rdy = (cyc % 3) != 1;
        out_ready = rdy;
        prev_stall = rst_n && out_valid && !rdy;
        prev_byte = {out_rd, out_dc, out_data};
        if (rst_n && out_valid && rdy) begin
            got = {out_rd, out_dc, out_data};
            if (expq.size() == 0) chk(0, "R9", "unexpected byte", got, 0);
            else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                chk(got == e, t, "byte {rd,dc,data}", got, e);
            end
            if (out_rd) rsp_cnt = 3;
        end
        rsp_valid = 1'b0;
        if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin rsp_valid = 1'b1; rsp_data = pm_val; end
        end
    end

    task automatic push(input logic [9:0] v, input string t);
        expq.push_back(v);
        tagq.push_back(t);
    endtask

    task automatic push_win(input logic [7:0] c, input int a, input int b, input string t);
        push({2'b00, c}, t);
        push({2'b01, 8'(a >> 8)}, t);
        push({2'b01, 8'(a)}, t);
        push({2'b01, 8'((b - 1) >> 8)}, t);
        push({2'b01, 8'(b - 1)}, t);
    endtask

    task automatic push_frame(input int x0, input int x1, input int y0, input int y1,
                              input bit zero, input string t);
        push_win(8'h2A, x0, x1, "R3");
        push_win(8'h2B, y0, y1, "R4");
        push({2'b00, 8'h2C}, t);
        for (int k = 0; k < (x1 - x0) * (y1 - y0); k++) begin
            logic [15:0] p;
            p = zero ? 16'h0000 : pixf(pix_idx + k);
            push({2'b01, p[15:8]}, t);
            push({2'b01, p[7:0]}, t);
        end
    endtask

    task automatic issue(input int op, input int x0, input int x1, input int y0, input int y1, input string t);
        int d0, p0;
        bit sq;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sq = 0; d0 = done_cnt; p0 = pix_idx;
        case (op)
            0: if (model_en) begin push_frame(x0, x1, y0, y1, 0, t); sq = 1; end
            1: begin model_en = 1; push_frame(0, HR, 0, VR, 0, t); sq = 1; end
            2: begin model_en = 0; if (!bl_present) begin push_frame(0, HR, 0, VR, 1, t); sq = 1; end end
            default: ;
        endcase
        req_valid = 1'b1; req_op = 2'(op);
        req_x0 = 16'(x0); req_x1 = 16'(x1); req_y0 = 16'(y0); req_y1 = 16'(y1);
        @(negedge clk);
        req_valid = 1'b0;
        if (sq) begin
            while (done_cnt == d0) @(negedge clk);
            repeat (3) @(negedge clk);
            chk(done_cnt == d0 + 1, "R9", "one done pulse", done_cnt - d0, 1);
            chk(expq.size() == 0, t, "bytes missing", expq.size(), 0);
        end else begin
            chk(req_ready == 1'b1, "R9", "ready after ignored request", req_ready, 1);
            repeat (30) @(negedge clk);
            chk(done_cnt == d0, t, "no sequence", done_cnt - d0, 0);
            chk(pix_idx == p0, t, "pixel source untouched", pix_idx - p0, 0);
        end
        if (op == 2) chk(pix_idx == p0, "R8", "no pixel fetch on blank", pix_idx - p0, 0);
    endtask

    task automatic boot(input logic [7:0] pm, input bit exp_on);
        rst_n = 1'b0;
        pm_val = pm; first_seen = 0; model_en = 0; rsp_cnt = 0;
        expq.delete(); tagq.delete();
        repeat (3) @(negedge clk);
        chk(!panel_rst_n && !out_valid && !req_ready && !pix_ready && !seq_done && !disp_on,
            "R1", "outputs in reset",
            {panel_rst_n, out_valid, req_ready, pix_ready, seq_done, disp_on}, 0);
        push({2'b10, 8'h0A}, "R2");
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk(disp_on == exp_on, "R2", "power-mode check", disp_on, exp_on);
        chk(expq.size() == 0, "R2", "read issued", expq.size(), 0);
    endtask

    initial begin
        boot(8'h9F, 1'b1);
        issue(0, 1, 3, 0, 2, "R6");
        issue(1, 0, 0, 0, 0, "R7");
        issue(0, 250, 258, 3, 5, "R5");
        issue(0, 5, 6, 0, 1, "R5");
        issue(3, 0, 4, 0, 4, "R9");
        issue(2, 0, 0, 0, 0, "R8");
        issue(0, 0, 2, 0, 2, "R6");
        issue(1, 0, 0, 0, 0, "R7");
        bl_present = 1'b1;
        issue(2, 0, 0, 0, 0, "R8");
        bl_present = 1'b0;
        boot(8'h5C, 1'b0);
        issue(0, 0, 1, 0, 1, "R6");
        finish_run();
    end
endmodule